// File: doc/BRIEF.md
# Register-Array LIFO Stack with Occupancy Flags

This block is a last-in, first-out store of 64 sixteen-bit words held in a register array. A 6-bit top pointer addresses the array and wraps modulo 64. Occupancy is not counted. Instead, two single-bit flags, `full_o` and `empty_o`, are set or cleared whenever an accepted operation leaves the pointer at zero.

A push strobe first advances the pointer and then writes the input word at the new position. The first item therefore lands at address 1, and the 64th item lands at address 0. A pop strobe copies the word at the current pointer into a registered output and then steps the pointer back. A popped word is not erased. It stays in the array until a later push writes over it. A surrounding datapath drives the strobes and reads `dout_o` one cycle after a pop. The pointer is brought out so that the stack position can be observed.

Top module: `lifo_regstack`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pointer becomes 0, `empty_o` becomes 1, `full_o` becomes 0 and `dout_o` becomes 0.
- R2: A push that is accepted (`push_i`=1, `pop_i`=0, `full_o`=0) has the following effects one cycle later: the pointer has advanced by one, `empty_o` is 0, and the input word is stored at the new pointer address.
- R3: `full_o` becomes 1 exactly when an accepted push moves the pointer to 0. This happens on the 64th push after reset, so the first item sits at address 1 and the 64th at address 0.
- R4: A pop that is accepted (`pop_i`=1, `push_i`=0, `empty_o`=0) has the following effects one cycle later: `dout_o` holds the word stored at the pre-pop pointer, the pointer has stepped back by one, and `full_o` is 0.
- R5: `empty_o` becomes 1 exactly when an accepted pop moves the pointer to 0.
- R6: A push while `full_o`=1 changes nothing. The pointer, the flags, `dout_o` and the stored words all keep their values.
- R7: A pop while `empty_o`=1 changes nothing. The pointer, the flags and `dout_o` all keep their values.
- R8: When `push_i` and `pop_i` are both 1 in the same cycle, neither operation takes place, and the state and `dout_o` keep their values.
- R9: `dout_o` changes only on the edge that completes an accepted pop.
- R10: The pointer wraps in both directions: a push from 63 gives 0, and a pop from 0 (stack full) gives 63.
- R11: Words are returned in reverse order of insertion. A popped word remains stored and is replaced by the next push to its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push strobe, one word per cycle |
| pop_i | input | 1 | Pop strobe, one word per cycle |
| din_i | input | 16 | Word to push |
| dout_o | output | 16 | Registered last popped word |
| full_o | output | 1 | Stack holds 64 words |
| empty_o | output | 1 | Stack holds no words |
| top_ptr_o | output | 6 | Current top-of-stack address |

## Verification
The assertions assume that both strobes are sampled as clean 0/1 levels on every edge after reset. They also assume that `din_i` matters only in a cycle where a push is accepted. No limit on strobe patterns is assumed, because the design must absorb overflow, underflow and collision attempts on its own.

The stimulus changes inputs only at falling edges. It deliberately drives pushes into a full stack, pops from an empty stack and simultaneous strobes. A long pseudo-random mix of operations is then compared against an arithmetic model of pointer, flags and stored words.

// File: rtl/lifo_pkg.sv
// Package: shared types and helpers for the register-array LIFO.
// Assumes: strobes are plain single-bit levels sampled on the rising edge.
package lifo_pkg;

    // Operation selected for one clock cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } lifo_op_e;

    // Decide the accepted operation: a collision or a blocked request is idle.
    function automatic lifo_op_e pick_op(input logic push,
                                         input logic pop,
                                         input logic is_full,
                                         input logic is_empty);
        lifo_op_e op;
        op = OP_IDLE;
        if (push && !pop && !is_full)
            op = OP_PUSH;
        else if (pop && !push && !is_empty)
            op = OP_POP;
        return op;
    endfunction

endpackage

// File: rtl/lifo_req_arb.sv
// Module: lifo_req_arb
// Turns the raw push/pop strobes into one accepted operation per cycle.
// Assumes: flag inputs come from registered state in lifo_ptr_flags.
module lifo_req_arb
    import lifo_pkg::*;
(
    input  logic     push_i,
    input  logic     pop_i,
    input  logic     full_i,
    input  logic     empty_i,
    output lifo_op_e op_o,
    output logic     do_push_o,
    output logic     do_pop_o
);

    // Select the cycle's operation and expose single-bit enables.
    always_comb begin
        op_o      = pick_op(push_i, pop_i, full_i, empty_i);
        do_push_o = (op_o == OP_PUSH);
        do_pop_o  = (op_o == OP_POP);
    end

    // Accepted enables never both fire.
    always_comb begin
        one_op_chk: assert (!(do_push_o && do_pop_o));
    end

endmodule

// File: rtl/lifo_ptr_flags.sv
// Module: lifo_ptr_flags
// Holds the wrapping top pointer and the full/empty flags; no count register.
// Assumes: at most one of do_push_i / do_pop_i is high in a cycle.
module lifo_ptr_flags #(
    parameter int unsigned PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req_i,
    input  logic             pop_req_i,
    input  logic             do_push_i,
    input  logic             do_pop_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] ptr_next_up_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam logic [PTR_W-1:0] PTR_ZERO = '0;
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;
    logic             full_q;
    logic             empty_q;

    // Neighbouring pointer values, wrapping modulo the depth.
    always_comb begin
        ptr_up = ptr_q + PTR_ONE;
        ptr_dn = ptr_q - PTR_ONE;
    end

    // Pointer register: pre-increment on push, post-decrement on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= PTR_ZERO;
        else if (do_push_i)
            ptr_q <= ptr_up;
        else if (do_pop_i)
            ptr_q <= ptr_dn;
    end

    // Flag registers driven by zero-detect of the new pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else if (do_push_i) begin
            full_q  <= (ptr_up == PTR_ZERO);
            empty_q <= 1'b0;
        end else if (do_pop_i) begin
            full_q  <= 1'b0;
            empty_q <= (ptr_dn == PTR_ZERO);
        end
    end

    assign ptr_o         = ptr_q;
    assign ptr_next_up_o = ptr_up;
    assign full_o        = full_q;
    assign empty_o       = empty_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (ptr_q == PTR_ZERO && empty_q && !full_q));

    // R2
    push_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req_i && !pop_req_i && !full_q) |=>
            (ptr_q == PTR_W'($past(ptr_q) + PTR_ONE) && !empty_q));

    // R4
    pop_retreat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req_i && !push_req_i && !empty_q) |=>
            (ptr_q == PTR_W'($past(ptr_q) - PTR_ONE) && !full_q));

    // R3
    full_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> (ptr_q == PTR_ZERO));

    // R5
    empty_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_q |-> (ptr_q == PTR_ZERO));

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_q && empty_q));

    // R6
    push_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req_i && !pop_req_i && full_q) |=>
            ($stable(ptr_q) && full_q && !empty_q));

    // R7
    pop_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req_i && !push_req_i && empty_q) |=>
            ($stable(ptr_q) && empty_q && !full_q));

    // R8
    collision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req_i && pop_req_i) |=>
            ($stable(ptr_q) && $stable(full_q) && $stable(empty_q)));

endmodule

// File: rtl/lifo_store.sv
// Module: lifo_store
// Register array with one write port and a registered read port.
// Assumes: write and read enables are never high together; contents are
// not reset, only the read register is.
module lifo_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Word write: overwrite whatever the addressed word held.
    always_ff @(posedge clk) begin
        if (wr_en_i)
            words_q[wr_addr_i] <= wr_data_i;
    end

    // Output register: capture the addressed word only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en_i)
            rd_q <= words_q[rd_addr_i];
    end

    assign rd_data_o = rd_q;

    // R9
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_q));

    // R8
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && rd_en_i));

endmodule

// File: rtl/lifo_regstack.sv
// Module: lifo_regstack (top)
// 2**PTR_W-word LIFO: arbiter, pointer/flag unit and register array.
// Assumes: one push or pop per cycle; collisions and blocked requests idle.
module lifo_regstack #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              full_o,
    output logic              empty_o,
    output logic [PTR_W-1:0]  top_ptr_o
);
    import lifo_pkg::*;

    lifo_op_e         op;
    logic             do_push;
    logic             do_pop;
    logic             full;
    logic             empty;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_up;

    lifo_req_arb u_arb (
        .push_i    (push_i),
        .pop_i     (pop_i),
        .full_i    (full),
        .empty_i   (empty),
        .op_o      (op),
        .do_push_o (do_push),
        .do_pop_o  (do_pop)
    );

    lifo_ptr_flags #(.PTR_W(PTR_W)) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_req_i    (push_i),
        .pop_req_i     (pop_i),
        .do_push_i     (do_push),
        .do_pop_i      (do_pop),
        .ptr_o         (ptr),
        .ptr_next_up_o (ptr_up),
        .full_o        (full),
        .empty_o       (empty)
    );

    // Push writes at the pre-incremented address; pop reads the current one.
    lifo_store #(.DATA_W(DATA_W), .ADDR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (do_push),
        .wr_addr_i (ptr_up),
        .wr_data_i (din_i),
        .rd_en_i   (do_pop),
        .rd_addr_i (ptr),
        .rd_data_o (dout_o)
    );

    assign full_o    = full;
    assign empty_o   = empty;
    assign top_ptr_o = ptr;

    // R7
    op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP) |-> !empty);

    // R6
    op_push_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH) |-> !full);

endmodule

// File: tb/lifo_regstack_tb.sv
`timescale 1ns/1ps
module lifo_regstack_tb;
    localparam int DW    = 16;
    localparam int PW    = 6;
    localparam int DEPTH = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          full;
    logic          empty;
    logic [PW-1:0] ptr;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    // Reference model state, computed from the requirements.
    logic [DW-1:0] m_mem [DEPTH];
    logic [PW-1:0] m_ptr;
    logic          m_full;
    logic          m_empty;
    logic [DW-1:0] m_dout;

    always #2.5 clk = ~clk;

    lifo_regstack u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .din_i(din),
        .dout_o(dout), .full_o(full), .empty_o(empty), .top_ptr_o(ptr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string req);
        chk({req, " ptr"},   32'(ptr),   32'(m_ptr));
        chk({req, " full"},  32'(full),  32'(m_full));
        chk({req, " empty"}, 32'(empty), 32'(m_empty));
        chk({req, " dout"},  32'(dout),  32'(m_dout));
    endtask

    // One cycle of stimulus, model update, then check at the next falling edge.
    task automatic step(input logic p, input logic q, input logic [DW-1:0] d, input string req);
        push = p; pop = q; din = d;
        if (p && !q && !m_full) begin
            m_ptr = m_ptr + 1'b1;
            m_mem[m_ptr] = d;
            m_full = (m_ptr == '0);
            m_empty = 1'b0;
        end else if (q && !p && !m_empty) begin
            m_dout = m_mem[m_ptr];
            m_ptr = m_ptr - 1'b1;
            m_empty = (m_ptr == '0);
            m_full = 1'b0;
        end
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        chk_all(req);
    endtask

    function automatic logic [DW-1:0] val(input int i);
        return DW'(i * 16'h0123 + 16'h1A00);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        logic [31:0] lcg;
        m_ptr = '0; m_full = 1'b0; m_empty = 1'b1; m_dout = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_all("R1");
        // R7 pop on empty ignored
        step(1'b0, 1'b1, 16'h0, "R7");
        // R2 R3 R10 fill completely; full only after the 64th push (ptr wraps 63->0)
        for (int i = 1; i <= DEPTH; i++) begin
            step(1'b1, 1'b0, val(i), (i == DEPTH) ? "R3_R10" : "R2");
            chk("R3 full timing", 32'(full), 32'(i == DEPTH));
        end
        // R6 push while full ignored
        step(1'b1, 1'b0, 16'hDEAD, "R6");
        // R8 collision while full
        step(1'b1, 1'b1, 16'hBEEF, "R8");
        // R4 R10 pop from ptr 0 gives 63 and returns the 64th word
        step(1'b0, 1'b1, 16'h0, "R4_R10");
        chk("R4 ptr after wrap pop", 32'(ptr), 32'(DEPTH - 1));
        // R11 popped slot overwritten by next push
        step(1'b1, 1'b0, 16'h5A5A, "R11");
        // R9 idle cycles hold dout
        repeat (3) step(1'b0, 1'b0, 16'hFFFF, "R9");
        // R4 R5 R11 drain in reverse order
        for (int i = DEPTH; i >= 1; i--) begin
            step(1'b0, 1'b1, 16'h0, (i == 1) ? "R5" : "R11");
            chk("R11 lifo order", 32'(dout), 32'((i == DEPTH) ? 16'h5A5A : val(i)));
        end
        // R7 R9 pop on empty keeps last word
        step(1'b0, 1'b1, 16'h0, "R7");
        // R8 collision mid-stack
        step(1'b1, 1'b0, 16'h1111, "R2");
        step(1'b1, 1'b0, 16'h2222, "R2");
        step(1'b1, 1'b1, 16'h3333, "R8");
        step(1'b0, 1'b1, 16'h0, "R8 followup");
        // Mixed pseudo-random sweep against the model
        lcg = 32'h1234_5678;
        for (int k = 0; k < 3000; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            step(lcg[28], lcg[27] & lcg[25], lcg[15:0], "R2_R4_mix");
        end
        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_ptr = '0; m_full = 1'b0; m_empty = 1'b1; m_dout = '0;
        chk_all("R1 rerun");
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            finish_run();
        end
    end
endmodule